// File: doc/BRIEF.md
# Internal Clock Source Selector

This block derives the system clock from two on-chip oscillators: a fast 8 MHz source and an independent slow source of nominally 31 kHz. The fast source feeds a power-of-two postscaler. A 3-bit rate code picks one of eight system clock rates. At the lowest rate, one extra bit decides whether that rate comes from the slow oscillator or from the fast source divided down.

Each change of source or divide ratio is handed over without runt pulses. The outgoing clock is gated off only while it is low. The output then stays low until the incoming clock is itself in a low phase, and only then is the incoming clock let through. The block also drives an enable for each oscillator, and it provides a quarter-rate copy of the system clock for test and synchronisation.

Top module: `intosc_clk_select`

## Requirements
- R1: For rate codes 1 to 7, `sys_clk` is the fast source divided by 2^(7-code): code 7 is the fast source itself, code 6 is half of it, and code 1 is 1/64 of it. Each high phase lasts exactly half of the period.
- R2: For rate code 0 with `slow_pick` = 0, `sys_clk` is the fast source divided by 256.
- R3: For rate code 0 with `slow_pick` = 1, `sys_clk` follows the slow source, with its period and its high time.
- R4: `slow_pick` has no effect for rate codes 1 to 7. The output rate does not change and `slow_osc_en` stays low.
- R5: `fast_osc_en` is high whenever the rate code is 1 to 7. It is also high for code 0 while the divided fast source is chosen. It goes low once the slow source has fully taken over.
- R6: `slow_osc_en` is high while code 0 with `slow_pick` = 1 is selected. After a handover away from the slow source it goes low.
- R7: `instr_clk` toggles every second rising edge of `sys_clk`, so its period is four `sys_clk` periods.
- R8: Every high pulse of `sys_clk` has the full high time of one valid setting. During a handover the output is held low. At most one source is gated to the output at any time.
- R9: While `rst` is high, `sys_clk` and `instr_clk` are low, `fast_osc_en` is high and `slow_osc_en` is low. The postscaler is cleared and set to the 1 MHz ratio (fast source divided by 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast internal source (8 MHz nominal) |
| slow_clk | input | 1 | Slow internal source (31 kHz nominal) |
| rst | input | 1 | Synchronous active-high reset, fast_clk domain |
| freq_sel | input | 3 | Rate code, 0 = 31.25 kHz, 1 = 125 kHz doubling up to 7 = 8 MHz |
| slow_pick | input | 1 | At rate code 0: 1 = slow source, 0 = fast source divided by 256 |
| sys_clk | output | 1 | Selected system clock |
| fast_osc_en | output | 1 | Enable for the fast oscillator |
| slow_osc_en | output | 1 | Enable for the slow oscillator |
| instr_clk | output | 1 | System clock divided by 4 |

## Verification
The assertions assume several things about the inputs. `freq_sel` and `slow_pick` change only in step with `fast_clk` and away from its edges. Both source clocks keep running, even while their enable is low, so that any pending handover can complete. `rst` changes away from every edge of both sources. The bench meets these assumptions. It drives every input one nanosecond after a rising fast edge, and it runs both sources freely with phases that never coincide with those drive times. It also switches codes in bursts shorter than a handover, so that the handover logic is exercised in the middle of a transition.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int SEL_W         = 3;
  localparam int NUM_CH        = 3;
  localparam int CH_FAST       = 0;   // undivided fast source
  localparam int CH_DIV        = 1;   // postscaled fast source
  localparam int CH_SLOW       = 2;   // separate slow source
  localparam int SLOW_DIV_LOG2 = 8;   // fast/256 at the slowest code
  localparam int HALF_W        = SLOW_DIV_LOG2;

  localparam logic [SEL_W-1:0] CODE_SLOWEST = '0;
  localparam logic [SEL_W-1:0] CODE_UNDIV   = '1;
  localparam logic [SEL_W-1:0] CODE_RESET   = SEL_W'(4);

  // fast-clock cycles per half period of the postscaled clock
  function automatic logic [HALF_W-1:0] half_of(input logic [SEL_W-1:0] code);
    logic [HALF_W-1:0] h;
    if (code == CODE_SLOWEST)
      h = HALF_W'(1) << (SLOW_DIV_LOG2 - 1);
    else if (code == CODE_UNDIV)
      h = HALF_W'(1);
    else
      h = HALF_W'(1) << (CODE_UNDIV - SEL_W'(1) - code);
    return h;
  endfunction
endpackage

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  freq_sel,
  input  logic              slow_pick,
  input  logic [NUM_CH-1:0] busy,
  output logic [NUM_CH-1:0] want,
  output logic [HALF_W-1:0] half,
  output logic              fast_en,
  output logic              slow_en
);
  logic [SEL_W-1:0] code_q;
  logic             pick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= CODE_RESET;
      pick_q  <= 1'b0;
      fast_en <= 1'b1;
      slow_en <= 1'b0;
    end else begin
      code_q  <= freq_sel;
      pick_q  <= slow_pick;
      fast_en <= want[CH_FAST] | want[CH_DIV] | busy[CH_FAST] | busy[CH_DIV];
      slow_en <= want[CH_SLOW] | busy[CH_SLOW];
    end
  end

  always_comb begin
    want = '0;
    if (code_q == CODE_UNDIV)
      want[CH_FAST] = 1'b1;
    else if ((code_q == CODE_SLOWEST) && pick_q)
      want[CH_SLOW] = 1'b1;
    else
      want[CH_DIV] = 1'b1;
  end

  assign half = half_of(code_q);

  // R5
  fast_en_chk: assert property (@(posedge clk) disable iff (rst)
    (code_q != CODE_SLOWEST) |=> fast_en);
  // R6
  slow_en_chk: assert property (@(posedge clk) disable iff (rst)
    want[CH_SLOW] |=> slow_en);
  // R6
  slow_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!want[CH_SLOW] && !busy[CH_SLOW]) |=> !slow_en);
endmodule

// File: rtl/clksel_postscaler.sv
module clksel_postscaler
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] half,
  output logic              dclk
);
  logic [HALF_W-1:0] hcnt;
  logic [HALF_W-1:0] half_q;

  // a new ratio is taken only as the divided clock falls, so every
  // high phase keeps the length it started with
  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      dclk   <= 1'b0;
      half_q <= half_of(CODE_RESET);
    end else if (hcnt == half_q - HALF_W'(1)) begin
      hcnt <= '0;
      dclk <= ~dclk;
      if (dclk)
        half_q <= half;
    end else begin
      hcnt <= hcnt + HALF_W'(1);
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt < half_q);
  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk) |-> $stable(half_q));
endmodule

// File: rtl/clksel_gate.sv
module clksel_gate #(
  parameter bit RST_ON    = 1'b0,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic ck,
  input  logic upd,
  input  logic rst,
  input  logic req,
  input  logic src,
  output logic on,
  output logic busy,
  output logic gated
);
  logic s1, s2;

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(negedge ck or posedge rst) begin
        if (rst) begin
          s1 <= RST_ON;
          s2 <= RST_ON;
        end else if (upd) begin
          s1 <= req;
          s2 <= s1;
        end
      end
    end else begin : g_sync
      always_ff @(negedge ck) begin
        if (rst) begin
          s1 <= RST_ON;
          s2 <= RST_ON;
        end else if (upd) begin
          s1 <= req;
          s2 <= s1;
        end
      end
    end
  endgenerate

  assign on    = s2;
  assign busy  = s1 | s2;
  assign gated = src & s2;

  // R8
  handoff_order_chk: assert property (@(negedge ck) disable iff (rst)
    $rose(s2) |-> $past(s1));
endmodule

// File: rtl/intosc_clk_select.sv
module intosc_clk_select
  import clksel_pkg::*;
(
  input  logic             fast_clk,
  input  logic             slow_clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] freq_sel,
  input  logic             slow_pick,
  output logic             sys_clk,
  output logic             fast_osc_en,
  output logic             slow_osc_en,
  output logic             instr_clk
);
  logic [NUM_CH-1:0] want, busy, on, gated, req;
  logic [NUM_CH-1:0] ch_ck, ch_src, ch_upd;
  logic [HALF_W-1:0] half;
  logic              dclk;
  logic [1:0]        qcnt;

  clksel_ctrl u_ctrl (
    .clk       (fast_clk),
    .rst       (rst),
    .freq_sel  (freq_sel),
    .slow_pick (slow_pick),
    .busy      (busy),
    .want      (want),
    .half      (half),
    .fast_en   (fast_osc_en),
    .slow_en   (slow_osc_en)
  );

  clksel_postscaler u_post (
    .clk  (fast_clk),
    .rst  (rst),
    .half (half),
    .dclk (dclk)
  );

  // divided-clock gate runs on the fast negedge but only moves while
  // the divided clock is low, so its gate never cuts a high phase
  assign ch_ck  = {slow_clk, fast_clk, fast_clk};
  assign ch_src = {slow_clk, dclk,     fast_clk};
  assign ch_upd = {1'b1,     ~dclk,    1'b1};

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      req[i] = want[i] & ~|(busy & ~(NUM_CH'(1) << i));
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      clksel_gate #(
        .RST_ON    (1'(g == CH_DIV)),
        .ASYNC_RST (1'(g == CH_SLOW))
      ) u_gate (
        .ck    (ch_ck[g]),
        .upd   (ch_upd[g]),
        .rst   (rst),
        .req   (req[g]),
        .src   (ch_src[g]),
        .on    (on[g]),
        .busy  (busy[g]),
        .gated (gated[g])
      );
    end
  endgenerate

  assign sys_clk = |gated;

  always_ff @(posedge sys_clk or posedge rst) begin
    if (rst) qcnt <= '0;
    else     qcnt <= qcnt + 2'd1;
  end
  assign instr_clk = qcnt[1];

  // R8
  one_source_chk: assert property (@(posedge fast_clk) disable iff (rst)
    $onehot0(on));
endmodule

// File: tb/intosc_clk_select_test.sv
`timescale 1ns/1ps
module intosc_clk_select_test;
  typedef struct packed {
    logic [2:0] code;
    logic       pick;
    int         per;
    logic       fen;
    logic       sen;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd7, 1'b0,    5, 1'b1, 1'b0},
    '{3'd6, 1'b0,   10, 1'b1, 1'b0},
    '{3'd5, 1'b1,   20, 1'b1, 1'b0},
    '{3'd4, 1'b0,   40, 1'b1, 1'b0},
    '{3'd3, 1'b1,   80, 1'b1, 1'b0},
    '{3'd2, 1'b0,  160, 1'b1, 1'b0},
    '{3'd1, 1'b0,  320, 1'b1, 1'b0},
    '{3'd0, 1'b0, 1280, 1'b1, 1'b0},
    '{3'd0, 1'b1, 1300, 1'b0, 1'b1},
    '{3'd6, 1'b1,   10, 1'b1, 1'b0},
    '{3'd0, 1'b1, 1300, 1'b0, 1'b1},
    '{3'd7, 1'b1,    5, 1'b1, 1'b0}
  };

  logic fast_clk = 1'b0, slow_clk = 1'b0, rst = 1'b1;
  logic [2:0] freq_sel = 3'd4;
  logic slow_pick = 1'b0;
  logic sys_clk, fast_osc_en, slow_osc_en, instr_clk;

  int nchk = 0, nfail = 0, runts = 0;
  bit mon_on = 1'b0, done = 1'b0;
  realtime t_rise = 0.0;

  intosc_clk_select uut (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst(rst),
    .freq_sel(freq_sel), .slow_pick(slow_pick), .sys_clk(sys_clk),
    .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en), .instr_clk(instr_clk)
  );

  always #2.5 fast_clk = ~fast_clk;            // 200 MHz
  initial begin
    #1.3;
    forever #650 slow_clk = ~slow_clk;         // 1300 ns period
  end

  function automatic bit near(real a, real b);
    return (a > b - 0.01) && (a < b + 0.01);
  endfunction

  function automatic bit legal_high(real w);
    return near(w, 2.5) || near(w, 5) || near(w, 10) || near(w, 20) ||
           near(w, 40) || near(w, 80) || near(w, 160) || near(w, 640) ||
           near(w, 650);
  endfunction

  // R8 pulse-width monitor
  always @(posedge sys_clk) t_rise = $realtime;
  always @(negedge sys_clk) begin
    if (mon_on && !legal_high($realtime - t_rise)) runts++;
  end

  task automatic check_int(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] c, logic p);
    @(posedge fast_clk); #1;
    freq_sel  = c;
    slow_pick = p;
  endtask

  task automatic wait_fast(int n);
    repeat (n) @(posedge fast_clk);
    #1;
  endtask

  task automatic measure(output int per, output int hi_tenths, output int iper);
    realtime t0, t1, t2;
    @(posedge sys_clk); t0 = $realtime;
    @(negedge sys_clk); t1 = $realtime;
    @(posedge sys_clk); t2 = $realtime;
    per       = $rtoi(t2 - t0 + 0.5);
    hi_tenths = $rtoi((t1 - t0) * 10.0 + 0.5);
    @(posedge instr_clk); t0 = $realtime;
    @(posedge instr_clk); t1 = $realtime;
    iper = $rtoi(t1 - t0 + 0.5);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int per, hi, iper, hits;
    string tag;

    // R9 reset state
    wait_fast(140);
    @(negedge fast_clk);
    check_int("R9 sys_clk in reset", int'(sys_clk), 0);
    check_int("R9 instr_clk in reset", int'(instr_clk), 0);
    check_int("R9 fast_osc_en in reset", int'(fast_osc_en), 1);
    check_int("R9 slow_osc_en in reset", int'(slow_osc_en), 0);
    @(posedge fast_clk); #1;
    rst = 1'b0;
    mon_on = 1'b1;
    measure(per, hi, iper);
    check_int("R9 period after reset", per, 40);

    // table of settings
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].code, VECS[v].pick);
      wait_fast(1600);
      measure(per, hi, iper);
      if (VECS[v].code == 3'd0) tag = VECS[v].pick ? "R3" : "R2";
      else                      tag = VECS[v].pick ? "R4" : "R1";
      check_int({tag, " period"}, per, VECS[v].per);
      check_int({tag, " high time x10"}, hi, VECS[v].per * 5);
      check_int("R7 instr_clk period", iper, VECS[v].per * 4);
      @(negedge fast_clk);
      check_int("R5 fast_osc_en", int'(fast_osc_en), int'(VECS[v].fen));
      check_int("R6 slow_osc_en", int'(slow_osc_en), int'(VECS[v].sen));
      check_int("R8 runt pulses", runts, 0);
    end

    // R4: toggling slow_pick at a non-zero code leaves slow_osc_en low
    drive(3'd3, 1'b0);
    wait_fast(1600);
    hits = 0;
    for (int k = 0; k < 300; k++) begin
      drive(3'd3, k[3]);
      @(negedge fast_clk);
      if (slow_osc_en) hits++;
    end
    check_int("R4 slow_osc_en while pick toggles", hits, 0);
    measure(per, hi, iper);
    check_int("R4 period while pick toggles", per, 80);

    // R8: rapid switching, handovers interrupted mid-way
    for (int k = 0; k < 40; k++) begin
      drive(3'((k * 5 + 3) % 8), k[0]);
      wait_fast((k * 7) % 23 + 1);
    end
    drive(3'd5, 1'b0);
    wait_fast(1600);
    measure(per, hi, iper);
    check_int("R8 period after switch burst", per, 20);
    check_int("R8 runt pulses after burst", runts, 0);

    // R2 vs R3: flip only the source bit at the slowest code
    drive(3'd0, 1'b1);
    wait_fast(1600);
    drive(3'd0, 1'b0);
    wait_fast(1600);
    measure(per, hi, iper);
    check_int("R2 period after leaving slow source", per, 1280);
    @(negedge fast_clk);
    check_int("R6 slow_osc_en after leaving slow source", int'(slow_osc_en), 0);
    check_int("R8 runt pulses final", runts, 0);

    finish_run();
  end
endmodule